// File: doc/BRIEF.md
# Streaming Hex Record Loader

This block turns a stream of ASCII characters, one per beat of `char_valid`, into memory writes. It expects the common colon-prefixed hexadecimal record format used to ship program images. Each record carries a byte count, a 16-bit load offset, a record type, its payload and a checksum, all written as pairs of hex digits. A typical source is a serial receiver; a typical sink is the write port of an on-chip RAM that must be filled before a processor leaves reset.

Payload bytes of data records are packed, most significant byte first, into words of `ceil(WORD_W/8)` bytes. Each word is written with a one-cycle `wr_en` pulse at the segment base plus the current offset, and the offset advances by one per word. A segment record sets the base for later data records to its 16-bit value times 16. An end record raises `done`, after which the block ignores its input until reset. Problems are reported through sticky flags. After an error the parser waits for the next colon and carries on from there.

Top module: `hexrec_loader`

## Requirements
- R1: Outside a record, a colon (0x3A) starts a record, carriage return (0x0D) and line feed (0x0A) are skipped with no flag, and any other character sets `err_char`.
- R2: Inside a record, the digits 0-9, A-F and a-f are hex digits, and both letter cases give the same value. Any other character, or a colon before the record has ended, sets `err_char` and abandons the record.
- R3: After the colon, the bytes are taken in this order: count, offset high byte, offset low byte, type, `count` payload bytes, checksum. Each byte is sent as two digits, high nibble first.
- R4: For type 0x00, each group of `ceil(WORD_W/8)` payload bytes forms one word, with the first byte most significant. The word is written with a single-cycle `wr_en` pulse at segment base + offset + word index.
- R5: A type 0x00 record whose count is not a multiple of the bytes per word sets `err_len` and writes nothing.
- R6: A type 0x02 record must have a count of 2, otherwise it sets `err_len`. With a correct checksum, its two payload bytes (high first) times 16 become the segment base for later data records.
- R7: If the 8-bit sum of count, offset bytes, type, payload and checksum is not zero, the record sets `err_sum`. A segment record with a bad sum leaves the base unchanged.
- R8: A type 0x01 record with a correct checksum sets `done`. From then until reset, all input is ignored: no writes and no new flags.
- R9: A type other than 0x00, 0x01 or 0x02 sets `err_type`, and the record writes nothing.
- R10: A word whose full address is at or above `MEM_DEPTH` sets `err_range`. The write is still issued, at the low `ADDR_W` bits of that address.
- R11: Synchronous active-high reset clears `done`, all error flags and the segment base, and leaves the parser waiting for a colon.
- R12: Error flags stay set until reset. After an error, the next colon starts a new record that is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | `char_data` holds a character this cycle |
| char_data | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | ADDR_W | Write address, truncated |
| wr_data | output | WORD_W | Assembled word |
| done | output | 1 | End record accepted |
| err_char | output | 1 | Illegal or misplaced character seen |
| err_type | output | 1 | Unknown record type seen |
| err_len | output | 1 | Bad count for the record type |
| err_sum | output | 1 | Checksum mismatch |
| err_range | output | 1 | Write at or beyond `MEM_DEPTH` |

## Verification
The bench sweeps data records of one to six words over a range of offsets, switching between upper- and lower-case digits. A byte-order or case bug shows up as wrong words in the bench's copy of memory, and an offset-stepping bug shows up as words in the wrong place. It sets segment bases with both good and corrupted checksums and then checks where later words land, so a base that is taken without checking the sum, or that survives reset, puts data at the wrong address. It places words on both sides of `MEM_DEPTH` and beyond the address width, which exposes off-by-one range checks and missing truncation. It also drives malformed records, junk characters and input after the end record, and checks that no write slips out, that the right single flag is set and that the next record resynchronises.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam int SEG_W  = 20;   // segment value << 4
    localparam int OFF_W  = 16;
    localparam int FULL_W = 21;   // base + offset without overflow

    localparam logic [7:0] REC_DATA = 8'h00;
    localparam logic [7:0] REC_EOF  = 8'h01;
    localparam logic [7:0] REC_SEG  = 8'h02;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    typedef enum logic [1:0] {
        ST_HUNT,   // between records
        ST_REC,    // inside a record
        ST_SKIP,   // abandoned record, wait for colon
        ST_END     // end record seen
    } ld_state_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] val;
    } nib_t;

    typedef struct packed {
        logic colon;
        logic eol;
        nib_t nib;
    } ch_class_t;

    function automatic int bytes_per_word(int w);
        return (w + 7) / 8;
    endfunction

    function automatic nib_t hex_decode(logic [7:0] c);
        nib_t n;
        n = '0;
        if (c >= 8'h30 && c <= 8'h39) begin
            n.ok = 1'b1; n.val = 4'(c - 8'h30);
        end else if (c >= 8'h41 && c <= 8'h46) begin
            n.ok = 1'b1; n.val = 4'(c - 8'h37);
        end else if (c >= 8'h61 && c <= 8'h66) begin
            n.ok = 1'b1; n.val = 4'(c - 8'h57);
        end
        return n;
    endfunction

endpackage

// File: rtl/hexrec_char_class.sv
module hexrec_char_class
    import hexrec_pkg::*;
(
    input  logic [7:0] char_data,
    output ch_class_t  cls
);
    always_comb begin
        cls.colon = (char_data == CH_COLON);
        cls.eol   = (char_data == CH_CR) || (char_data == CH_LF);
        cls.nib   = hex_decode(char_data);
    end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
    import hexrec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  ch_class_t         cls,
    output logic              rec_start,
    output logic [FULL_W-1:0] rec_addr,
    output logic              byte_stb,
    output logic [7:0]        byte_out,
    output logic              done,
    output logic              err_chr,
    output logic              err_typ,
    output logic              err_len,
    output logic              err_sum
);
    localparam int BPW = bytes_per_word(WORD_W);

    ld_state_e         state;
    logic [3:0]        hi_nib;
    logic              have_hi;
    logic [8:0]        pos;
    logic [7:0]        count;
    logic [OFF_W-1:0]  offset;
    logic [7:0]        rtype;
    logic [7:0]        sum;
    logic [15:0]       seg_val;
    logic [SEG_W-1:0]  seg_base;
    logic [7:0]        cur;
    logic [8:0]        data_end;

    always_comb begin
        cur      = {hi_nib, cls.nib.val};
        data_end = 9'd4 + {1'b0, count};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            hi_nib    <= '0;
            have_hi   <= 1'b0;
            pos       <= '0;
            count     <= '0;
            offset    <= '0;
            rtype     <= '0;
            sum       <= '0;
            seg_val   <= '0;
            seg_base  <= '0;
            rec_start <= 1'b0;
            rec_addr  <= '0;
            byte_stb  <= 1'b0;
            byte_out  <= '0;
            done      <= 1'b0;
            err_chr   <= 1'b0;
            err_typ   <= 1'b0;
            err_len   <= 1'b0;
            err_sum   <= 1'b0;
        end else begin
            rec_start <= 1'b0;
            byte_stb  <= 1'b0;
            if (char_valid && state != ST_END) begin
                if (cls.colon) begin
                    if (state == ST_REC) err_chr <= 1'b1;
                    state   <= ST_REC;
                    pos     <= '0;
                    have_hi <= 1'b0;
                    sum     <= '0;
                end else begin
                    case (state)
                        ST_HUNT: if (!cls.eol) begin
                            err_chr <= 1'b1;
                            state   <= ST_SKIP;
                        end
                        ST_REC: if (!cls.nib.ok) begin
                            err_chr <= 1'b1;
                            state   <= ST_SKIP;
                        end else if (!have_hi) begin
                            hi_nib  <= cls.nib.val;
                            have_hi <= 1'b1;
                        end else begin
                            have_hi <= 1'b0;
                            pos     <= pos + 9'd1;
                            sum     <= sum + cur;
                            if (pos == 9'd0) begin
                                count <= cur;
                            end else if (pos == 9'd1) begin
                                offset[15:8] <= cur;
                            end else if (pos == 9'd2) begin
                                offset[7:0] <= cur;
                            end else if (pos == 9'd3) begin
                                rtype <= cur;
                                if (cur > REC_SEG) begin
                                    err_typ <= 1'b1;
                                    state   <= ST_SKIP;
                                end else if (cur == REC_SEG && count != 8'd2) begin
                                    err_len <= 1'b1;
                                    state   <= ST_SKIP;
                                end else if (cur == REC_DATA && (int'(count) % BPW) != 0) begin
                                    err_len <= 1'b1;
                                    state   <= ST_SKIP;
                                end else if (cur == REC_DATA) begin
                                    rec_start <= 1'b1;
                                    rec_addr  <= FULL_W'(seg_base) + FULL_W'(offset);
                                end
                            end else if (pos < data_end) begin
                                if (rtype == REC_DATA) begin
                                    byte_stb <= 1'b1;
                                    byte_out <= cur;
                                end
                                if (rtype == REC_SEG) seg_val <= {seg_val[7:0], cur};
                            end else begin
                                state <= ST_HUNT;
                                if (8'(sum + cur) != 8'd0) begin
                                    err_sum <= 1'b1;
                                end else if (rtype == REC_EOF) begin
                                    done  <= 1'b1;
                                    state <= ST_END;
                                end else if (rtype == REC_SEG) begin
                                    seg_base <= {seg_val, 4'h0};
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R8: once the end record is taken, done holds and no payload flows
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    a_r8_no_payload_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!byte_stb && !rec_start));
    // R12: no error flag ever falls outside reset
    a_r12_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (($past({err_chr, err_typ, err_len, err_sum}) & ~{err_chr, err_typ, err_len, err_sum}) == 4'b0));
    // R2: a record start and a payload byte never share a cycle
    a_r2_start_vs_byte: assert property (@(posedge clk) disable iff (rst)
        !(rec_start && byte_stb));

endmodule

// File: rtl/hexrec_word_pack.sv
module hexrec_word_pack
    import hexrec_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int MEM_DEPTH = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_start,
    input  logic [FULL_W-1:0] rec_addr,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              err_rng
);
    localparam int BPW   = bytes_per_word(WORD_W);
    localparam int ACC_W = BPW * 8;
    localparam int CNT_W = $clog2(BPW) + 1;

    logic [FULL_W-1:0] ptr;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_nxt;
    logic [CNT_W-1:0]  cnt;

    always_comb acc_nxt = ACC_W'({acc, byte_in});

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            acc     <= '0;
            cnt     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            err_rng <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (rec_start) begin
                ptr <= rec_addr;
                cnt <= '0;
            end else if (byte_stb) begin
                acc <= acc_nxt;
                if (cnt == CNT_W'(BPW - 1)) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr[ADDR_W-1:0];
                    wr_data <= acc_nxt[WORD_W-1:0];
                    if (ptr >= FULL_W'(MEM_DEPTH)) err_rng <= 1'b1;
                    ptr <= ptr + 1'b1;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: writes are single-cycle pulses
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    // R10: the range flag only rises together with a write
    a_r10_range_on_write: assert property (@(posedge clk) disable iff (rst)
        $rose(err_rng) |-> wr_en);

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int MEM_DEPTH = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [7:0]        char_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              err_char,
    output logic              err_type,
    output logic              err_len,
    output logic              err_sum,
    output logic              err_range
);
    ch_class_t         cls;
    logic              rec_start;
    logic [FULL_W-1:0] rec_addr;
    logic              byte_stb;
    logic [7:0]        byte_val;

    hexrec_char_class u_class (
        .char_data (char_data),
        .cls       (cls)
    );

    hexrec_parser #(.WORD_W(WORD_W)) u_parse (
        .clk        (clk),
        .rst        (rst),
        .char_valid (char_valid),
        .cls        (cls),
        .rec_start  (rec_start),
        .rec_addr   (rec_addr),
        .byte_stb   (byte_stb),
        .byte_out   (byte_val),
        .done       (done),
        .err_chr    (err_char),
        .err_typ    (err_type),
        .err_len    (err_len),
        .err_sum    (err_sum)
    );

    hexrec_word_pack #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .MEM_DEPTH (MEM_DEPTH)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .rec_start (rec_start),
        .rec_addr  (rec_addr),
        .byte_stb  (byte_stb),
        .byte_in   (byte_val),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .err_rng   (err_range)
    );

    // R8: no write once done is set
    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

endmodule

// File: tb/hexrec_loader_bench.sv
module hexrec_loader_bench;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 200;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              char_valid = 1'b0;
    logic [7:0]        char_data = 8'h00;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              done, err_char, err_type, err_len, err_sum, err_range;

    hexrec_loader #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MEM_DEPTH(DEPTH)) u_hexrec_loader (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .err_char(err_char), .err_type(err_type), .err_len(err_len),
        .err_sum(err_sum), .err_range(err_range)
    );

    logic [WORD_W-1:0] mem_m [0:255];
    int wr_cnt = 0;
    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] rb [0:15];

    always @(negedge clk) if (!rst && wr_en) begin
        mem_m[wr_addr] = wr_data;
        wr_cnt = wr_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] flags();
        return {err_char, err_type, err_len, err_sum, err_range};
    endfunction
    // flag vector bit order: char, type, len, sum, range
    localparam logic [4:0] F_CHR = 5'b10000, F_TYP = 5'b01000, F_LEN = 5'b00100,
                           F_SUM = 5'b00010, F_RNG = 5'b00001;

    task automatic put(input logic [7:0] c);
        @(negedge clk);
        char_valid = 1'b1;
        char_data  = c;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
    endfunction

    task automatic put_byte(input logic [7:0] b, input bit lower, inout logic [7:0] s);
        put(hexc(b[7:4], lower));
        put(hexc(b[3:0], lower));
        s = s + b;
    endtask

    task automatic send_rec(input int cnt, input logic [15:0] off, input logic [7:0] typ,
                            input bit lower, input logic [7:0] adj);
        logic [7:0] s;
        s = 8'h00;
        put(8'h3A);
        put_byte(8'(cnt), lower, s);
        put_byte(off[15:8], lower, s);
        put_byte(off[7:0], lower, s);
        put_byte(typ, lower, s);
        for (int i = 0; i < cnt; i++) put_byte(rb[i], lower, s);
        put_byte((~s) + 8'd1 + adj, lower, s);
        put(8'h0D);
        put(8'h0A);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        wr_cnt = 0;
    endtask

    function automatic logic [7:0] pat(input int r, input int i);
        return 8'(r * 37 + i * 11 + 5);
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        do_reset();
        // R11: reset state
        check("R11 reset flags", {27'd0, flags()}, 32'd0);
        check("R11 reset done/wr_en", {30'd0, done, wr_en}, 32'd0);

        // R3/R4/R2: sweep of data records, alternating digit case
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 2 * (r + 1); i++) rb[i] = pat(r, i);
            send_rec(2 * (r + 1), 16'(r * 20), 8'h00, r[0], 8'h00);
        end
        for (int r = 0; r < 6; r++)
            for (int w = 0; w <= r; w++)
                check(r[0] ? "R2 R4 lower-case word" : "R3 R4 word",
                      {16'd0, mem_m[r * 20 + w]}, {16'd0, pat(r, 2 * w), pat(r, 2 * w + 1)});
        check("R4 write count", wr_cnt, 21);
        check("R4 untouched location", {16'd0, mem_m[19]}, 32'd0);
        check("R1 CR/LF skipped", {27'd0, flags()}, 32'd0);

        // R6: segment base 0x0002 -> 0x20
        rb[0] = 8'h00; rb[1] = 8'h02;
        send_rec(2, 16'h0000, 8'h02, 1'b0, 8'h00);
        rb[0] = 8'hAB; rb[1] = 8'hCD;
        send_rec(2, 16'h0005, 8'h00, 1'b0, 8'h00);
        check("R6 segment applied", {16'd0, mem_m[8'h25]}, 32'h0000ABCD);
        check("R6 no flags", {27'd0, flags()}, 32'd0);

        // R7: corrupted segment record keeps base 0x20
        rb[0] = 8'h00; rb[1] = 8'h05;
        send_rec(2, 16'h0000, 8'h02, 1'b0, 8'h01);
        rb[0] = 8'h12; rb[1] = 8'h34;
        send_rec(2, 16'h0001, 8'h00, 1'b0, 8'h00);
        check("R7 base unchanged", {16'd0, mem_m[8'h21]}, 32'h00001234);
        check("R7 sum flag", {27'd0, flags()}, {27'd0, F_SUM});

        // R11: reset clears the segment base
        do_reset();
        rb[0] = 8'h56; rb[1] = 8'h78;
        send_rec(2, 16'h0005, 8'h00, 1'b0, 8'h00);
        check("R11 base cleared", {16'd0, mem_m[5]}, 32'h00005678);
        check("R11 flags clear", {27'd0, flags()}, 32'd0);

        // R10: range boundary
        do_reset();
        rb[0] = 8'h11; rb[1] = 8'h22; rb[2] = 8'h33; rb[3] = 8'h44;
        send_rec(4, 16'd198, 8'h00, 1'b0, 8'h00);
        check("R10 below depth", {27'd0, flags()}, 32'd0);
        send_rec(4, 16'd199, 8'h00, 1'b0, 8'h00);
        check("R10 at depth flag", {27'd0, flags()}, {27'd0, F_RNG});
        check("R10 word at depth", {16'd0, mem_m[200]}, 32'h00003344);
        do_reset();
        rb[0] = 8'h00; rb[1] = 8'h10;           // base 0x100
        send_rec(2, 16'h0000, 8'h02, 1'b0, 8'h00);
        rb[0] = 8'hDE; rb[1] = 8'hAD; rb[2] = 8'hBE; rb[3] = 8'hEF;
        send_rec(4, 16'h0003, 8'h00, 1'b0, 8'h00);
        check("R10 truncated addr 3", {16'd0, mem_m[3]}, 32'h0000DEAD);
        check("R10 truncated addr 4", {16'd0, mem_m[4]}, 32'h0000BEEF);
        check("R10 range flag", {27'd0, flags()}, {27'd0, F_RNG});

        // R9: unknown type
        do_reset();
        rb[0] = 8'h01; rb[1] = 8'h02;
        send_rec(2, 16'h0000, 8'h05, 1'b0, 8'h00);
        check("R9 type flag", {27'd0, flags()}, {27'd0, F_TYP});
        check("R9 no write", wr_cnt, 0);

        // R5: odd data count
        do_reset();
        rb[0] = 8'h01; rb[1] = 8'h02; rb[2] = 8'h03;
        send_rec(3, 16'h0000, 8'h00, 1'b0, 8'h00);
        check("R5 len flag", {27'd0, flags()}, {27'd0, F_LEN});
        check("R5 no write", wr_cnt, 0);

        // R6: segment record with count 1
        do_reset();
        rb[0] = 8'h01;
        send_rec(1, 16'h0000, 8'h02, 1'b0, 8'h00);
        check("R6 len flag", {27'd0, flags()}, {27'd0, F_LEN});

        // R2/R12: bad digit, then resync
        do_reset();
        put(8'h3A); put(8'h30); put(8'h47); put(8'h31); put(8'h32);
        rb[0] = 8'h9A; rb[1] = 8'hBC;
        send_rec(2, 16'h0007, 8'h00, 1'b1, 8'h00);
        check("R2 char flag", {27'd0, flags()}, {27'd0, F_CHR});
        check("R12 resync write", {16'd0, mem_m[7]}, 32'h00009ABC);

        // R1: junk between records
        do_reset();
        put(8'h78);
        rb[0] = 8'h0F; rb[1] = 8'hF0;
        send_rec(2, 16'h0008, 8'h00, 1'b0, 8'h00);
        check("R1 junk flag", {27'd0, flags()}, {27'd0, F_CHR});
        check("R1 record after junk", {16'd0, mem_m[8]}, 32'h00000FF0);

        // R8: end record, then input ignored
        do_reset();
        send_rec(0, 16'h0000, 8'h01, 1'b0, 8'h00);
        check("R8 done", {31'd0, done}, 32'd1);
        rb[0] = 8'h77; rb[1] = 8'h88;
        send_rec(2, 16'h0009, 8'h00, 1'b0, 8'h00);
        put(8'h5A);
        repeat (4) @(negedge clk);
        check("R8 no write after done", wr_cnt, 0);
        check("R8 flags unchanged", {26'd0, done, flags()}, {26'd0, 1'b1, 5'd0});

        summary();
    end
endmodule